// File: doc/BRIEF.md
# Load-Scheduled Dead-Time Interpolator

This block turns a sampled load-current code into a synchronous-rectifier dead-time command. The command is read off a piecewise-linear curve held in a small table of programmable vertices. One instance produces one dead-time, so a converter controller uses two instances: one for the turn-on edge and one for the turn-off edge. Each current sample first passes through a first-order low-pass stage. This stage sets how quickly the dead-time follows load changes, independently of any slower loop that tunes the curve.

The curve has seven vertices. Five equal segments span the low-current range. The segment holding a given current is found by shifting the current code right, which takes the floor of the code divided by the segment width. One much wider segment runs from the knee to the last vertex, and it is weighted with a precomputed reciprocal of its width. Along with the interpolated dead-time, the block exports the indices of the two vertices that bracket the current and the weight of each one. An external adaptation engine uses these to update exactly those two vertices. Vertex writes arrive on a simple write port. A strobe always interpolates over the table as it stood before that strobe's clock edge.

The current code has a resolution of 1/32 A. With the default parameters the vertices sit at codes 0, 128, 256, 384, 512, 640 and 2400, which correspond to 0, 4, 8, 12, 16, 20 and 75 A.

Top module: `dt_sched`

## Requirements
- R1: After a synchronous reset, dt_out, idx_lo, idx_hi, wt_lo and wt_hi are 0, dt_valid is 0, and the low-pass state is 0.
- R2: For a filtered code f below 640, idx_lo = floor(f/128). For 640 <= f < 2400, idx_lo = 5. In every valid result idx_hi = idx_lo + 1.
- R3: Weights are 9-bit with 256 meaning one. Below 640, wt_hi = 2*(f mod 128). For 640 <= f < 2400, wt_hi = floor((f-640)*595/4096). In both ranges wt_lo = 256 - wt_hi.
- R4: For f >= 2400 the result is clamped: idx_lo = 5, idx_hi = 6, wt_hi = 256, wt_lo = 0.
- R5: Vertex values are 10-bit with 2 fractional bits (quarter LSB). The raw dead-time is (v[idx_lo]*wt_lo + v[idx_hi]*wt_hi + 512) >> 10, so a half LSB rounds up.
- R6: When dt_min <= dt_max, the raw dead-time is clamped into [dt_min, dt_max] before it reaches dt_out.
- R7: On each strobe the low-pass state s is updated as s <= s + code - (s >> 2), and the filtered value used by that same strobe is the new s >> 2. Without a strobe, s holds.
- R8: If a strobe is sampled at clock edge n, the outputs update at edge n+1 and dt_valid is high for the cycle after edge n+1. Between results, all outputs hold their values.
- R9: A vertex write (vw_en, address 0 to 6) sampled at the same edge as a strobe does not affect that strobe's result. It does affect the next one. A write sampled at an earlier edge is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_code | input | 12 | Load-current sample, 1/32 A per code |
| smp_stb | input | 1 | Sample strobe: filter and interpolate this cycle |
| vw_en | input | 1 | Vertex write enable |
| vw_addr | input | 3 | Vertex index to write |
| vw_data | input | 10 | Vertex value in quarter DPWM LSBs |
| dt_min | input | 8 | Lower dead-time limit in DPWM LSBs |
| dt_max | input | 8 | Upper dead-time limit in DPWM LSBs |
| dt_out | output | 8 | Interpolated, rounded and saturated dead-time |
| dt_valid | output | 1 | One-cycle pulse marking a new result |
| idx_lo | output | 3 | Lower bracketing vertex index |
| idx_hi | output | 3 | Upper bracketing vertex index |
| wt_lo | output | 9 | Weight of the lower vertex, 256 = one |
| wt_hi | output | 9 | Weight of the upper vertex, 256 = one |

## Verification
A vertex write and a sample strobe can land on the same clock edge. That strobe must still interpolate over the old vertex value while the write commits. The bench provokes this by driving vw_en and smp_stb in the same cycle for the vertex that brackets a settled zero-current sample. It judges the case by requiring the old dead-time on that result and the new dead-time on the following strobe. It then rewrites the vertex one edge ahead of a strobe to show that an earlier write is used at once.

// File: rtl/dt_sched_pkg.sv
package dt_sched_pkg;

  // Default geometry: 12-bit current at 1/32 A, seven vertices,
  // 4 A uniform segments up to the knee, last vertex at 75 A.
  localparam int DEF_CUR_W     = 12;
  localparam int DEF_N_VTX     = 7;
  localparam int DEF_SEG_SHIFT = 7;
  localparam int DEF_LAST_PT   = 2400;
  localparam int DEF_VTX_W     = 10;
  localparam int DEF_VFRAC     = 2;
  localparam int DEF_WGT_W     = 8;
  localparam int DEF_RECIP_SH  = 12;
  localparam int DEF_LPF_SHIFT = 2;

  // Fixed-point reciprocal of the wide segment span, scaled so that
  // (offset * recip) >> sh gives a WGT_W-bit fraction.
  function automatic int recip_of(input int span, input int wgt_w, input int sh);
    return (1 << (wgt_w + sh)) / span;
  endfunction

endpackage

// File: rtl/dt_sched_lpf.sv
module dt_sched_lpf #(
  parameter int CUR_W = 12,
  parameter int SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [CUR_W-1:0] cur,
  output logic [CUR_W-1:0] filt
);
  localparam int ACC_W = CUR_W + SHIFT;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;

  // State holds the filtered value scaled by 2^SHIFT; true result fits ACC_W.
  assign acc_nxt = acc_q + ACC_W'(cur) - (acc_q >> SHIFT);
  assign filt    = CUR_W'(acc_nxt >> SHIFT);

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (stb) acc_q <= acc_nxt;
  end

  // R7: filter state moves only on a strobe
  p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(acc_q));

endmodule

// File: rtl/dt_sched_bracket.sv
module dt_sched_bracket #(
  parameter int CUR_W     = 12,
  parameter int N_VTX     = 7,
  parameter int SEG_SHIFT = 7,
  parameter int LAST_PT   = 2400,
  parameter int WGT_W     = 8,
  parameter int RECIP_SH  = 12
) (
  input  logic [CUR_W-1:0]         filt,
  output logic [$clog2(N_VTX)-1:0] idx_lo,
  output logic [$clog2(N_VTX)-1:0] idx_hi,
  output logic [WGT_W:0]           wt_lo,
  output logic [WGT_W:0]           wt_hi
);
  localparam int IDX_W = $clog2(N_VTX);
  localparam int KNEE  = (N_VTX - 2) << SEG_SHIFT;
  localparam int RECIP = dt_sched_pkg::recip_of(LAST_PT - KNEE, WGT_W, RECIP_SH);
  localparam int RW    = $clog2(RECIP + 1);
  localparam int PW    = CUR_W + RW;
  localparam logic [CUR_W-1:0] KNEE_C = CUR_W'(KNEE);
  localparam logic [CUR_W-1:0] LAST_C = CUR_W'(LAST_PT);
  localparam logic [WGT_W:0]   ONE    = (WGT_W+1)'(1) << WGT_W;
  localparam logic [IDX_W-1:0] TOP_LO = IDX_W'(N_VTX - 2);

  logic [WGT_W:0] uni_frac;
  logic [PW-1:0]  prod;

  // Position inside a uniform segment, rescaled to WGT_W fraction bits.
  generate
    if (SEG_SHIFT >= WGT_W) begin : g_trunc
      assign uni_frac = {1'b0, filt[SEG_SHIFT-1 -: WGT_W]};
    end else begin : g_widen
      assign uni_frac = (WGT_W+1)'(filt[SEG_SHIFT-1:0]) << (WGT_W - SEG_SHIFT);
    end
  endgenerate

  // Wide last segment: multiply by precomputed reciprocal instead of dividing.
  assign prod = PW'(filt - KNEE_C) * PW'(RECIP);

  always_comb begin
    if (filt >= LAST_C) begin
      idx_lo = TOP_LO;
      wt_hi  = ONE;
    end else if (filt >= KNEE_C) begin
      idx_lo = TOP_LO;
      wt_hi  = (WGT_W+1)'(prod >> RECIP_SH);
    end else begin
      idx_lo = IDX_W'(filt >> SEG_SHIFT);
      wt_hi  = uni_frac;
    end
    idx_hi = idx_lo + IDX_W'(1);
    wt_lo  = ONE - wt_hi;
  end

endmodule

// File: rtl/dt_sched_vtx.sv
module dt_sched_vtx #(
  parameter int N_VTX = 7,
  parameter int VTX_W = 10
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(N_VTX)-1:0] waddr,
  input  logic [VTX_W-1:0]         wdata,
  input  logic [$clog2(N_VTX)-1:0] raddr_a,
  input  logic [$clog2(N_VTX)-1:0] raddr_b,
  output logic [VTX_W-1:0]         rdata_a,
  output logic [VTX_W-1:0]         rdata_b
);
  localparam int IDX_W = $clog2(N_VTX);
  localparam logic [IDX_W-1:0] LIM = IDX_W'(N_VTX);

  logic [VTX_W-1:0] mem [N_VTX];

  // Plain write-port memory without reset, suited to distributed RAM.
  always_ff @(posedge clk) begin
    if (we && (waddr < LIM)) mem[waddr] <= wdata;
  end

  // Asynchronous reads see contents from before a same-edge write.
  assign rdata_a = (raddr_a < LIM) ? mem[raddr_a] : '0;
  assign rdata_b = (raddr_b < LIM) ? mem[raddr_b] : '0;

endmodule

// File: rtl/dt_sched_interp.sv
module dt_sched_interp #(
  parameter int VTX_W = 10,
  parameter int VFRAC = 2,
  parameter int WGT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_vld,
  input  logic [VTX_W-1:0]       v_lo,
  input  logic [VTX_W-1:0]       v_hi,
  input  logic [WGT_W:0]         wt_lo,
  input  logic [WGT_W:0]         wt_hi,
  input  logic [VTX_W-VFRAC-1:0] dt_min,
  input  logic [VTX_W-VFRAC-1:0] dt_max,
  output logic [VTX_W-VFRAC-1:0] dt_q,
  output logic                   vld_q
);
  localparam int DT_W  = VTX_W - VFRAC;
  localparam int SH    = WGT_W + VFRAC;
  localparam int SUM_W = VTX_W + WGT_W + 2;
  localparam int Q_W   = SUM_W - SH;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (SH - 1);

  logic [SUM_W-1:0] sum_w;
  logic [Q_W-1:0]   q;
  logic [DT_W-1:0]  sat;

  assign sum_w = SUM_W'(v_lo) * SUM_W'(wt_lo) + SUM_W'(v_hi) * SUM_W'(wt_hi) + HALF;
  assign q     = Q_W'(sum_w >> SH);

  always_comb begin
    if (q > Q_W'(dt_max))      sat = dt_max;
    else if (q < Q_W'(dt_min)) sat = dt_min;
    else                       sat = DT_W'(q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dt_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) dt_q <= sat;
    end
  end

  // R6: a fresh result lies inside the limits it was computed with
  p_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (vld_q && $past(dt_min) <= $past(dt_max)) |->
      (dt_q >= $past(dt_min) && dt_q <= $past(dt_max)));

endmodule

// File: rtl/dt_sched.sv
module dt_sched
  import dt_sched_pkg::*;
#(
  parameter int CUR_W     = DEF_CUR_W,
  parameter int N_VTX     = DEF_N_VTX,
  parameter int SEG_SHIFT = DEF_SEG_SHIFT,
  parameter int LAST_PT   = DEF_LAST_PT,
  parameter int VTX_W     = DEF_VTX_W,
  parameter int VFRAC     = DEF_VFRAC,
  parameter int WGT_W     = DEF_WGT_W,
  parameter int RECIP_SH  = DEF_RECIP_SH,
  parameter int LPF_SHIFT = DEF_LPF_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CUR_W-1:0]         cur_code,
  input  logic                     smp_stb,
  input  logic                     vw_en,
  input  logic [$clog2(N_VTX)-1:0] vw_addr,
  input  logic [VTX_W-1:0]         vw_data,
  input  logic [VTX_W-VFRAC-1:0]   dt_min,
  input  logic [VTX_W-VFRAC-1:0]   dt_max,
  output logic [VTX_W-VFRAC-1:0]   dt_out,
  output logic                     dt_valid,
  output logic [$clog2(N_VTX)-1:0] idx_lo,
  output logic [$clog2(N_VTX)-1:0] idx_hi,
  output logic [WGT_W:0]           wt_lo,
  output logic [WGT_W:0]           wt_hi
);
  localparam int IDX_W = $clog2(N_VTX);
  localparam int WT_W  = WGT_W + 1;
  localparam logic [WT_W:0]    ONE_X  = (WT_W+1)'(1) << WGT_W;
  localparam logic [IDX_W-1:0] TOP_LO = IDX_W'(N_VTX - 2);

  logic [CUR_W-1:0] filt;
  logic [IDX_W-1:0] b_lo, b_hi;
  logic [WT_W-1:0]  b_wlo, b_whi;
  logic [VTX_W-1:0] r_lo, r_hi;

  // Stage 1 registers: bracket, weights and both vertex values together.
  logic             s1_vld;
  logic [IDX_W-1:0] s1_lo, s1_hi;
  logic [WT_W-1:0]  s1_wlo, s1_whi;
  logic [VTX_W-1:0] s1_vlo, s1_vhi;

  dt_sched_lpf #(.CUR_W(CUR_W), .SHIFT(LPF_SHIFT)) u_lpf (
    .clk(clk), .rst(rst), .stb(smp_stb), .cur(cur_code), .filt(filt)
  );

  dt_sched_bracket #(
    .CUR_W(CUR_W), .N_VTX(N_VTX), .SEG_SHIFT(SEG_SHIFT),
    .LAST_PT(LAST_PT), .WGT_W(WGT_W), .RECIP_SH(RECIP_SH)
  ) u_bracket (
    .filt(filt), .idx_lo(b_lo), .idx_hi(b_hi), .wt_lo(b_wlo), .wt_hi(b_whi)
  );

  dt_sched_vtx #(.N_VTX(N_VTX), .VTX_W(VTX_W)) u_vtx (
    .clk(clk), .we(vw_en), .waddr(vw_addr), .wdata(vw_data),
    .raddr_a(b_lo), .raddr_b(b_hi), .rdata_a(r_lo), .rdata_b(r_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_lo  <= '0;
      s1_hi  <= '0;
      s1_wlo <= '0;
      s1_whi <= '0;
      s1_vlo <= '0;
      s1_vhi <= '0;
    end else begin
      s1_vld <= smp_stb;
      if (smp_stb) begin
        s1_lo  <= b_lo;
        s1_hi  <= b_hi;
        s1_wlo <= b_wlo;
        s1_whi <= b_whi;
        s1_vlo <= r_lo;
        s1_vhi <= r_hi;
      end
    end
  end

  dt_sched_interp #(.VTX_W(VTX_W), .VFRAC(VFRAC), .WGT_W(WGT_W)) u_interp (
    .clk(clk), .rst(rst), .in_vld(s1_vld),
    .v_lo(s1_vlo), .v_hi(s1_vhi), .wt_lo(s1_wlo), .wt_hi(s1_whi),
    .dt_min(dt_min), .dt_max(dt_max), .dt_q(dt_out), .vld_q(dt_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_lo <= '0;
      idx_hi <= '0;
      wt_lo  <= '0;
      wt_hi  <= '0;
    end else if (s1_vld) begin
      idx_lo <= s1_lo;
      idx_hi <= s1_hi;
      wt_lo  <= s1_wlo;
      wt_hi  <= s1_whi;
    end
  end

  // R3: the two exported weights always add up to one
  p_wsum_r3: assert property (@(posedge clk) disable iff (rst)
    dt_valid |-> ((WT_W+1)'(wt_lo) + (WT_W+1)'(wt_hi)) == ONE_X);

  // R2: exported vertices are neighbours
  p_adjacent_r2: assert property (@(posedge clk) disable iff (rst)
    dt_valid |-> idx_hi == idx_lo + IDX_W'(1));

  // R4: full weight on the upper vertex only happens in the clamped last segment
  p_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    (dt_valid && wt_hi == WT_W'(ONE_X)) |-> idx_lo == TOP_LO);

  // R8: a result appears two edges after its strobe
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (dt_valid == $past(smp_stb, 2)));

  // R8: outputs hold while no new result is presented
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !dt_valid) |->
      ($stable(dt_out) && $stable(idx_lo) && $stable(wt_hi)));

endmodule

// File: tb/dt_sched_bench.sv
`timescale 1ns/1ps
module dt_sched_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [11:0] cur_code;
  logic       smp_stb;
  logic       vw_en;
  logic [2:0] vw_addr;
  logic [9:0] vw_data;
  logic [7:0] dt_min, dt_max;
  logic [7:0] dt_out;
  logic       dt_valid;
  logic [2:0] idx_lo, idx_hi;
  logic [8:0] wt_lo, wt_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Vertex contents in quarter LSBs, mirrored in the bench.
  int vtx [7] = '{400, 300, 200, 120, 80, 60, 20};

  // current code, expected idx_lo, expected wt_hi
  localparam int NV = 14;
  localparam int VEC [NV][3] = '{
    '{0,    0, 0},   '{64,   0, 128}, '{127,  0, 254}, '{128,  1, 0},
    '{200,  1, 144}, '{384,  3, 0},   '{639,  4, 254}, '{640,  5, 0},
    '{1000, 5, 52},  '{1080, 5, 63},  '{1520, 5, 127}, '{2399, 5, 255},
    '{2400, 5, 256}, '{4095, 5, 256}
  };

  always #10 clk = ~clk;

  dt_sched u_dt_sched (
    .clk(clk), .rst(rst), .cur_code(cur_code), .smp_stb(smp_stb),
    .vw_en(vw_en), .vw_addr(vw_addr), .vw_data(vw_data),
    .dt_min(dt_min), .dt_max(dt_max), .dt_out(dt_out), .dt_valid(dt_valid),
    .idx_lo(idx_lo), .idx_hi(idx_hi), .wt_lo(wt_lo), .wt_hi(wt_hi)
  );

  function automatic int ref_dt(input int lo, input int whi, input int mn, input int mx);
    int s, q;
    s = vtx[lo] * (256 - whi) + vtx[lo + 1] * whi;
    q = (s + 512) / 1024;
    if (q > mx)      q = mx;
    else if (q < mn) q = mn;
    return q;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr_vtx(input int a, input int d);
    vw_en = 1'b1; vw_addr = 3'(a); vw_data = 10'(d);
    @(negedge clk);
    vw_en = 1'b0;
  endtask

  // Strobe on the next edge, return one cycle after the result edge.
  task automatic strobe(input int c);
    cur_code = 12'(c); smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle(input int c);
    repeat (48) strobe(c);
  endtask

  task automatic chk_all(input string tag, input int lo, input int whi);
    chk($sformatf("R2 idx_lo %s", tag), int'(idx_lo), lo);
    chk($sformatf("R2 idx_hi %s", tag), int'(idx_hi), lo + 1);
    chk($sformatf("R3 wt_hi %s", tag), int'(wt_hi), whi);
    chk($sformatf("R3 wt_lo %s", tag), int'(wt_lo), 256 - whi);
    chk($sformatf("R5 dt_out %s", tag), int'(dt_out),
        ref_dt(lo, whi, int'(dt_min), int'(dt_max)));
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      report();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cur_code = '0; smp_stb = 1'b0;
    vw_en = 1'b0; vw_addr = '0; vw_data = '0;
    dt_min = 8'd2; dt_max = 8'd120;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 dt_out", int'(dt_out), 0);
    chk("R1 dt_valid", int'(dt_valid), 0);
    chk("R1 idx_lo", int'(idx_lo), 0);
    chk("R1 idx_hi", int'(idx_hi), 0);
    chk("R1 wt_hi", int'(wt_hi), 0);
    chk("R1 wt_lo", int'(wt_lo), 0);

    for (int k = 0; k < 7; k++) wr_vtx(k, vtx[k]);

    // R7: step response from zero state, filtered 100 then 175
    strobe(400);
    chk("R7 first step idx_lo", int'(idx_lo), 0);
    chk("R7 first step wt_hi", int'(wt_hi), 200);
    chk("R7 first step dt", int'(dt_out), ref_dt(0, 200, 2, 120));
    // R8: pulse present now, gone next cycle with outputs held
    chk("R8 valid pulse", int'(dt_valid), 1);
    @(negedge clk);
    chk("R8 valid drops", int'(dt_valid), 0);
    chk("R8 dt held", int'(dt_out), ref_dt(0, 200, 2, 120));
    strobe(400);
    chk("R7 second step idx_lo", int'(idx_lo), 1);
    chk("R7 second step wt_hi", int'(wt_hi), 94);

    // R2 R3 R4 R5: vector walk over settled currents
    for (int i = 0; i < NV; i++) begin
      settle(VEC[i][0]);
      chk_all($sformatf("vec %0d cur %0d", i, VEC[i][0]), VEC[i][1], VEC[i][2]);
    end
    // R4: clamp explicitly at the top of range
    chk("R4 clamp wt_lo", int'(wt_lo), 0);
    chk("R4 clamp idx_hi", int'(idx_hi), 6);

    // R5: 87.5 LSB rounds up to 88
    settle(64);
    chk("R5 half rounds up", int'(dt_out), 88);

    // R6: saturation on both limits
    settle(4095);
    chk("R6 unclamped low", int'(dt_out), 5);
    dt_min = 8'd25;
    strobe(4095);
    chk("R6 raised to min", int'(dt_out), 25);
    dt_min = 8'd2;
    settle(0);
    chk("R6 unclamped high", int'(dt_out), 100);
    dt_max = 8'd60;
    strobe(0);
    chk("R6 cut to max", int'(dt_out), 60);
    dt_max = 8'd120;

    // R9: write on the same edge as a strobe is not seen by it
    vw_en = 1'b1; vw_addr = 3'd0; vw_data = 10'd200;
    cur_code = 12'd0; smp_stb = 1'b1;
    @(negedge clk);
    vw_en = 1'b0; smp_stb = 1'b0;
    @(negedge clk);
    chk("R9 same-edge write unseen", int'(dt_out), 100);
    strobe(0);
    chk("R9 write seen next strobe", int'(dt_out), 50);
    wr_vtx(0, 400);
    strobe(0);
    chk("R9 earlier write seen", int'(dt_out), 100);

    done = 1'b1;
    report();
    $finish;
  end

endmodule